// File: doc/BRIEF.md
# Compressed Value/Tag Output Packer

This block sits behind a top-4 selector. Each group yields four winners, and each winner is a value with a 16-bit position inside its group. The block turns these pairs into words for two write streams, one for data and one for tags. Both streams use a valid/ready handshake.

A static configuration selects the layout:

- **Interleaved mode** puts the value and its tag side by side in one word, and the tag stream stays idle.
- **Split mode** sends values on the data stream and tags on the tag stream.
  - With packing off, each tag is written at its own width.
  - With packing on, four 4-bit tags are gathered into one 16-bit word.

The block checks the configuration before it accepts any input. An illegal pairing raises an error and stops all intake.

Inputs arrive one pair per handshake on `in_valid`/`in_ready`. Each output stream has a one-entry register, and a pair is accepted only when every stream it will write to can take the word. The configuration is assumed to change only while the block is idle and between groups. Reset is synchronous and active-low.

Top module: `cvt_packer`

## Requirements
- R1: Interleaved mode with 8-bit data (`cfg_data16`=0) writes `dat_word` = {16'h0, index[7:0], value[7:0]} one cycle after the pair is accepted, and never raises `tag_valid`.
- R2: Interleaved mode with 16-bit data (`cfg_data16`=1) writes `dat_word` = {index[15:0], value[15:0]}.
- R3: In interleaved mode, 8-bit data requires `cfg_struct_w`=1 (16-bit struct) and 16-bit data requires `cfg_struct_w`=2 (32-bit struct). Width codes are 0=8, 1=16, 2=32 and 3=reserved; every other pairing is illegal.
- R4: Split mode (`cfg_mode`=1) with `cfg_pack`=0 writes one data word and one tag word per pair. The data word is the value zero-extended from the data width. The tag word is index[7:0] for `cfg_tag_w`=0, and the index zero-extended for codes 1 and 2. Code 3 is illegal.
- R5: Split mode with `cfg_pack`=1 is legal only with `cfg_tag_w`=1 (16 bits).
- R6: In packed split mode, a data word is written for every pair. A tag word is written only after the fourth pair of a group. Bits [3:0] of that word hold the first pair's index nibble, and bits [15:12] hold the fourth; bits [31:16] are zero.
- R7: In packed mode, an index above 15 sets `pkd_ovf`. The flag stays set until reset.
- R8: While the configuration is illegal, `cfg_err` is 1, `in_ready` is 0 and no new word is written on either stream.
- R9: While an output is valid and its ready is low, the word holds steady and `in_ready` stays 0 for any pair that needs that stream.
- R10: After reset, `dat_valid`, `tag_valid` and `pkd_ovf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 1 | 0 = interleaved, 1 = split |
| cfg_pack | input | 1 | Split mode: pack 4-bit tags four per word |
| cfg_data16 | input | 1 | 0 = 8-bit data, 1 = 16-bit data |
| cfg_struct_w | input | 2 | Interleaved struct width code |
| cfg_tag_w | input | 2 | Split-mode tag width code |
| in_valid | input | 1 | Pair available |
| in_ready | output | 1 | Pair accepted this cycle when valid |
| in_value | input | 16 | Winner value |
| in_index | input | 16 | Winner position within its group |
| dat_valid | output | 1 | Data word valid |
| dat_ready | input | 1 | Data sink ready |
| dat_word | output | 32 | Data word |
| tag_valid | output | 1 | Tag word valid |
| tag_ready | input | 1 | Tag sink ready |
| tag_word | output | 32 | Tag word |
| cfg_err | output | 1 | Illegal configuration |
| pkd_ovf | output | 1 | Sticky packed-index overflow |

## Verification
A slot counter that drifts shows up at the next packed group. The tag word then appears after the wrong pair, or its nibbles sit in rotated positions, so the fault is visible within four accepted pairs.

A wrong nibble in the accumulator is seen on the one tag word that completes that group. A hold register that lets go under backpressure changes `dat_word` in the very next stalled cycle.

The legality decode is checked at once, by comparing `cfg_err` and `in_ready` for each configuration in the table.

// File: rtl/cvt_pkg.sv
// Shared widths and encodings for the value/tag packer.
// Assumes 16-bit values and indices and 32-bit output words.
package cvt_pkg;
    localparam int VAL_W   = 16;
    localparam int IDX_W   = 16;
    localparam int WORD_W  = 32;
    localparam int NIB_W   = 4;
    localparam int GROUP_N = 4;
    localparam int BYTE_W  = 8;

    typedef enum logic {
        MODE_INTL  = 1'b0,
        MODE_SPLIT = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        WC_8   = 2'd0,
        WC_16  = 2'd1,
        WC_32  = 2'd2,
        WC_RSV = 2'd3
    } wcode_e;
endpackage

// File: rtl/cvt_cfg_check.sv
// Decides whether the format configuration is legal.
// Purely combinational; assumes the configuration is quasi-static.
module cvt_cfg_check
    import cvt_pkg::*;
(
    input  mode_e  mode,
    input  logic   pack,
    input  logic   data16,
    input  wcode_e struct_w,
    input  wcode_e tag_w,
    output logic   err
);
    // Legality decode per mode.
    always_comb begin
        if (mode == MODE_SPLIT) begin
            if (pack) err = (tag_w != WC_16);
            else      err = (tag_w == WC_RSV);
        end else begin
            err = data16 ? (struct_w != WC_32) : (struct_w != WC_16);
        end
    end
endmodule

// File: rtl/cvt_tag_packer.sv
// Tracks the slot within a group and gathers the low index nibbles
// of the first GROUP_N-1 pairs. The last pair's nibble is merged by
// the caller. Also keeps the sticky overflow flag for indices that do
// not fit a nibble. Assumes step is asserted only in packed mode.
module cvt_tag_packer
    import cvt_pkg::*;
#(
    parameter int NW = NIB_W,
    parameter int GN = GROUP_N,
    parameter int IW = IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  logic [IW-1:0]        index,
    output logic                 slot_last,
    output logic [NW*(GN-1)-1:0] acc,
    output logic                 ovf
);
    localparam int SW = $clog2(GN);
    localparam logic [SW-1:0] LAST = SW'(GN - 1);

    logic [SW-1:0] slot;

    assign slot_last = (slot == LAST);

    // Slot counter: wraps after the last pair of a group.
    always_ff @(posedge clk) begin
        if (!rst_n)    slot <= '0;
        else if (step) slot <= slot_last ? '0 : slot + 1'b1;
    end

    // One nibble register per early slot.
    for (genvar g = 0; g < GN - 1; g++) begin : g_nib
        always_ff @(posedge clk) begin
            if (!rst_n)
                acc[g*NW +: NW] <= '0;
            else if (step && slot == SW'(g))
                acc[g*NW +: NW] <= index[NW-1:0];
        end
    end

    // Sticky overflow when an index needs more than a nibble.
    always_ff @(posedge clk) begin
        if (!rst_n)    ovf <= 1'b0;
        else if (step && |index[IW-1:NW]) ovf <= 1'b1;
    end

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
endmodule

// File: rtl/cvt_out_slot.sv
// One-entry output register for a valid/ready write stream.
// Assumes the caller loads only when the slot is empty or draining.
module cvt_out_slot #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] word_in,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] word
);
    // Hold the word until the sink takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            word  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            word  <= word_in;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(word)));
endmodule

// File: rtl/cvt_packer.sv
// Packs top-4 {value, index} pairs into data and tag write streams.
// Interleaved mode: one {tag, data} word per pair. Split mode: a data
// stream plus a tag stream, unpacked or four nibbles per word.
// Assumes the configuration changes only between groups while idle.
module cvt_packer
    import cvt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mode,
    input  logic              cfg_pack,
    input  logic              cfg_data16,
    input  logic [1:0]        cfg_struct_w,
    input  logic [1:0]        cfg_tag_w,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [VAL_W-1:0]  in_value,
    input  logic [IDX_W-1:0]  in_index,
    output logic              dat_valid,
    input  logic              dat_ready,
    output logic [WORD_W-1:0] dat_word,
    output logic              tag_valid,
    input  logic              tag_ready,
    output logic [WORD_W-1:0] tag_word,
    output logic              cfg_err,
    output logic              pkd_ovf
);
    localparam int HALF   = WORD_W / 2;
    localparam int ACC_W  = NIB_W * (GROUP_N - 1);
    localparam int PK_PAD = WORD_W - NIB_W * GROUP_N;

    mode_e             mode;
    logic              split, packed_on, need_tag, fire;
    logic              slot_last;
    logic [ACC_W-1:0]  acc;
    logic [WORD_W-1:0] dat_fmt, tag_fmt;

    assign mode      = mode_e'(cfg_mode);
    assign split     = (mode == MODE_SPLIT);
    assign packed_on = split && cfg_pack;

    cvt_cfg_check u_chk (
        .mode     (mode),
        .pack     (cfg_pack),
        .data16   (cfg_data16),
        .struct_w (wcode_e'(cfg_struct_w)),
        .tag_w    (wcode_e'(cfg_tag_w)),
        .err      (cfg_err)
    );

    // Does this pair produce a tag word?
    always_comb begin
        if (!split)         need_tag = 1'b0;
        else if (packed_on) need_tag = slot_last;
        else                need_tag = 1'b1;
    end

    // Accept only when every target stream has room and config is legal.
    assign in_ready = !cfg_err
                   && (!dat_valid || dat_ready)
                   && (!need_tag || !tag_valid || tag_ready);
    assign fire = in_valid && in_ready;

    cvt_tag_packer u_pk (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (fire && packed_on),
        .index     (in_index),
        .slot_last (slot_last),
        .acc       (acc),
        .ovf       (pkd_ovf)
    );

    // Data word formatting for both layouts.
    always_comb begin
        if (!split) begin
            if (cfg_data16) dat_fmt = {in_index[HALF-1:0], in_value[HALF-1:0]};
            else            dat_fmt = {{HALF{1'b0}}, in_index[BYTE_W-1:0],
                                       in_value[BYTE_W-1:0]};
        end else begin
            if (cfg_data16) dat_fmt = {{HALF{1'b0}}, in_value[HALF-1:0]};
            else            dat_fmt = {{(WORD_W-BYTE_W){1'b0}}, in_value[BYTE_W-1:0]};
        end
    end

    // Tag word formatting: packed nibbles or width-fitted index.
    always_comb begin
        if (packed_on)
            tag_fmt = {{PK_PAD{1'b0}}, in_index[NIB_W-1:0], acc};
        else if (wcode_e'(cfg_tag_w) == WC_8)
            tag_fmt = {{(WORD_W-BYTE_W){1'b0}}, in_index[BYTE_W-1:0]};
        else
            tag_fmt = {{(WORD_W-IDX_W){1'b0}}, in_index};
    end

    cvt_out_slot #(.W(WORD_W)) u_dat (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (fire),
        .word_in (dat_fmt),
        .ready   (dat_ready),
        .valid   (dat_valid),
        .word    (dat_word)
    );

    cvt_out_slot #(.W(WORD_W)) u_tag (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (fire && need_tag),
        .word_in (tag_fmt),
        .ready   (tag_ready),
        .valid   (tag_valid),
        .word    (tag_word)
    );

    // R1
    intl_no_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tag_valid) |-> $past(cfg_mode));

    // R6
    pack_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tag_valid) && $past(packed_on)) |-> $past(slot_last));

    // R8
    err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dat_valid) |-> !$past(cfg_err));
endmodule

// File: tb/cvt_packer_tb.sv
module cvt_packer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_mode = 1'b0, cfg_pack = 1'b0, cfg_data16 = 1'b0;
    logic [1:0]  cfg_struct_w = 2'd1, cfg_tag_w = 2'd0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_value = '0, in_index = '0;
    logic        dat_valid, tag_valid, cfg_err, pkd_ovf;
    logic        dat_ready = 1'b1, tag_ready = 1'b1;
    logic [31:0] dat_word, tag_word;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #10 clk = ~clk;   // 50 MHz

    cvt_packer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_pack(cfg_pack),
        .cfg_data16(cfg_data16), .cfg_struct_w(cfg_struct_w),
        .cfg_tag_w(cfg_tag_w), .in_valid(in_valid), .in_ready(in_ready),
        .in_value(in_value), .in_index(in_index), .dat_valid(dat_valid),
        .dat_ready(dat_ready), .dat_word(dat_word), .tag_valid(tag_valid),
        .tag_ready(tag_ready), .tag_word(tag_word), .cfg_err(cfg_err),
        .pkd_ovf(pkd_ovf)
    );

    // Row layout: {mode, pack, data16, struct_w[1:0], tag_w[1:0], exp_err}
    localparam logic [7:0] CFG_TAB [12] = '{
        {1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0},
        {1'b0, 1'b0, 1'b0, 2'd2, 2'd0, 1'b1},
        {1'b0, 1'b0, 1'b1, 2'd2, 2'd0, 1'b0},
        {1'b0, 1'b0, 1'b1, 2'd1, 2'd0, 1'b1},
        {1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1},
        {1'b0, 1'b0, 1'b1, 2'd3, 2'd0, 1'b1},
        {1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0},
        {1'b1, 1'b0, 1'b1, 2'd0, 2'd2, 1'b0},
        {1'b1, 1'b0, 1'b0, 2'd0, 2'd3, 1'b1},
        {1'b1, 1'b1, 1'b0, 2'd0, 2'd1, 1'b0},
        {1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 1'b1},
        {1'b1, 1'b1, 1'b1, 2'd0, 2'd2, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic m, input logic p, input logic d16,
                           input logic [1:0] sw, input logic [1:0] tw);
        @(negedge clk);
        cfg_mode = m; cfg_pack = p; cfg_data16 = d16;
        cfg_struct_w = sw; cfg_tag_w = tw;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    // Present one pair, let it be taken at the edge, return at the next negedge.
    task automatic send(input logic [15:0] v, input logic [15:0] i);
        @(negedge clk);
        in_valid = 1'b1; in_value = v; in_index = i;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin : watchdog
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        do_reset();
        @(negedge clk);
        // R10 reset state
        check("R10 dat_valid", {31'b0, dat_valid}, 32'd0);
        check("R10 tag_valid", {31'b0, tag_valid}, 32'd0);
        check("R10 pkd_ovf",   {31'b0, pkd_ovf},   32'd0);

        // Legality table: R3 (interleaved), R4 (split), R5 (packed), R8 (stall)
        for (int k = 0; k < 12; k++) begin
            set_cfg(CFG_TAB[k][7], CFG_TAB[k][6], CFG_TAB[k][5],
                    CFG_TAB[k][4:3], CFG_TAB[k][2:1]);
            #1;
            if (!CFG_TAB[k][7])     check("R3 cfg_err", {31'b0, cfg_err}, {31'b0, CFG_TAB[k][0]});
            else if (!CFG_TAB[k][6]) check("R4 cfg_err", {31'b0, cfg_err}, {31'b0, CFG_TAB[k][0]});
            else                     check("R5 cfg_err", {31'b0, cfg_err}, {31'b0, CFG_TAB[k][0]});
            check("R8 in_ready", {31'b0, in_ready}, {31'b0, ~CFG_TAB[k][0]});
        end

        // R1 interleaved 8-bit
        set_cfg(1'b0, 1'b0, 1'b0, 2'd1, 2'd0);
        send(16'h12AB, 16'h0305);
        check("R1 dat_valid", {31'b0, dat_valid}, 32'd1);
        check("R1 dat_word", dat_word, 32'h0000_05AB);
        check("R1 tag_valid", {31'b0, tag_valid}, 32'd0);

        // R2 interleaved 16-bit
        set_cfg(1'b0, 1'b0, 1'b1, 2'd2, 2'd0);
        send(16'hBEEF, 16'h0007);
        check("R2 dat_word", dat_word, 32'h0007_BEEF);
        check("R2 tag_valid", {31'b0, tag_valid}, 32'd0);

        // R4 split unpacked, 8-bit data, 8-bit tag
        set_cfg(1'b1, 1'b0, 1'b0, 2'd0, 2'd0);
        send(16'h3456, 16'h0123);
        check("R4 dat_word 8", dat_word, 32'h0000_0056);
        check("R4 tag_valid", {31'b0, tag_valid}, 32'd1);
        check("R4 tag_word 8", tag_word, 32'h0000_0023);
        // R4 split unpacked, 16-bit data, 32-bit tag
        set_cfg(1'b1, 1'b0, 1'b1, 2'd0, 2'd2);
        send(16'hCAFE, 16'h0321);
        check("R4 dat_word 16", dat_word, 32'h0000_CAFE);
        check("R4 tag_word 32", tag_word, 32'h0000_0321);

        // R8 illegal config: no intake, no writes
        set_cfg(1'b0, 1'b0, 1'b0, 2'd2, 2'd0);
        @(negedge clk);
        in_valid = 1'b1; in_value = 16'h7777; in_index = 16'h0001;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check("R8 in_ready", {31'b0, in_ready}, 32'd0);
            check("R8 dat_valid", {31'b0, dat_valid}, 32'd0);
        end
        in_valid = 1'b0;

        // R6 packed groups
        do_reset();
        set_cfg(1'b1, 1'b1, 1'b0, 2'd0, 2'd1);
        send(16'h0010, 16'h0001);
        check("R6 tag early", {31'b0, tag_valid}, 32'd0);
        check("R6 dat_word", dat_word, 32'h0000_0010);
        send(16'h0011, 16'h0002);
        check("R6 tag early", {31'b0, tag_valid}, 32'd0);
        send(16'h0012, 16'h0003);
        check("R6 tag early", {31'b0, tag_valid}, 32'd0);
        send(16'h0013, 16'h0004);
        check("R6 tag_valid", {31'b0, tag_valid}, 32'd1);
        check("R6 tag_word", tag_word, 32'h0000_4321);
        check("R6 dat_word", dat_word, 32'h0000_0013);
        send(16'h0020, 16'h000F);
        send(16'h0021, 16'h0000);
        send(16'h0022, 16'h000A);
        send(16'h0023, 16'h0005);
        check("R6 tag_word 2", tag_word, 32'h0000_5A0F);
        check("R7 no ovf", {31'b0, pkd_ovf}, 32'd0);

        // R7 overflow sticky
        send(16'h0030, 16'h0012);
        check("R7 ovf set", {31'b0, pkd_ovf}, 32'd1);
        send(16'h0031, 16'h0001);
        send(16'h0032, 16'h0001);
        send(16'h0033, 16'h0001);
        check("R6 tag_word trunc", tag_word, 32'h0000_1112);
        check("R7 ovf held", {31'b0, pkd_ovf}, 32'd1);

        // R9 backpressure on the data stream
        set_cfg(1'b0, 1'b0, 1'b1, 2'd2, 2'd0);
        dat_ready = 1'b0;
        send(16'h1111, 16'h0001);
        check("R9 dat_word", dat_word, 32'h0001_1111);
        in_valid = 1'b1; in_value = 16'h2222; in_index = 16'h0002;
        #1;
        check("R9 in_ready", {31'b0, in_ready}, 32'd0);
        @(negedge clk);
        check("R9 hold", dat_word, 32'h0001_1111);
        check("R9 valid held", {31'b0, dat_valid}, 32'd1);
        dat_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 next word", dat_word, 32'h0002_2222);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule